// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt requests from two banks of 32 sources and reduces them to one CPU interrupt line and a 7-bit vector that names the most urgent pending source. The first bank (primary) mixes level sources, whose status tracks the input, and edge sources, which are captured in a sticky latch. Three primary positions carry no input of their own. Each of them summarises one group of the second bank (secondary), so a whole group of secondary sources reaches the CPU through a single primary bit.

Every source input passes through a two-flop synchronizer before use. A rising edge on an edge-type source sets a latch bit. Software clears that bit by writing 0 to its position, and a write of 1 leaves it unchanged. A small register port lets software read primary status, secondary status and the latches, and read or write the two mask registers and a software-interrupt register. When the lowest pending primary bit is a summary bit, the vector is taken from the secondary bank instead and is placed in a separate range starting at 32.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the primary mask (address 1), primary latch (address 2), soft register (address 3), secondary status (address 4) and secondary mask (address 5) read 0, and `cpu_irq_o` and `vec_valid_o` are low.
- R2: Primary level bits 0–3, 7–15, 20–21 and 25–27 show the synchronized input in primary status (address 0) and drop when the input drops.
- R3: Primary edge bits 16–19, 22–24 and 28–31 set on a 0-to-1 input transition. They stay set in the primary latch (address 2) and in primary status after the input falls.
- R4: A write to address 2 clears each latch bit written as 0 and keeps each latch bit written as 1.
- R5: If a new rising edge on a bit and a write that clears the same bit take effect in the same cycle, the bit stays set.
- R6: Only bits 28–30 of the soft register (address 3) can be written, and all its other bits read 0. Soft bits OR into primary status at the same positions.
- R7: Secondary bits 16, 22 and 28 latch on a rising edge and are cleared by writing 0 to that bit at address 4. All other secondary bits follow their synchronized input.
- R8: Primary status bit 6 is the OR of secondary bits 0–7 that are pending, bit 5 covers secondary bits 8–15, and bit 4 covers secondary bits 16–31. Secondary pending means secondary status AND secondary mask.
- R9: `cpu_irq_o` and `vec_valid_o` are high exactly when primary status AND primary mask is nonzero.
- R10: The vector is the index of the lowest-numbered pending primary bit (0–31).
- R11: When the winning primary bit is 4, 5 or 6, the vector is 32 plus the index of the lowest pending secondary bit.
- R12: Address 0 is read-only. Writes to it change no register, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_src_i | input | 32 | Primary source requests, asynchronous |
| sec_src_i | input | 32 | Secondary source requests, asynchronous |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 7 | Vector of the winning source: 0–31 primary, 32–63 secondary |
| vec_valid_o | output | 1 | The vector is meaningful |

## Verification
The assertions assume that each write is a single-cycle strobe with its address and data stable at the clock edge. They also assume that a source which should be seen holds its level for at least three cycles, so that both synchronizer stages and the edge register capture it. The bench drives every input on the falling clock edge. It holds source levels for four cycles before it samples, and it times the one race case, a new edge against a software clear, by counting the synchronizer stages so that both land on the same rising edge.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int PRI_W  = 32;
  localparam int SEC_W  = 32;
  localparam int ADDR_W = 3;
  localparam int VEC_W  = 7;
  localparam int IDX_W  = $clog2(PRI_W);
  localparam int SEC_VEC_BASE = 32;

  // primary bit classes
  localparam logic [PRI_W-1:0] PRI_EDGE_BITS  = 32'hF1CF_0000;
  localparam logic [PRI_W-1:0] PRI_SUM_BITS   = 32'h0000_0070;
  localparam logic [PRI_W-1:0] PRI_LEVEL_BITS = ~(PRI_EDGE_BITS | PRI_SUM_BITS);
  localparam logic [PRI_W-1:0] SOFT_BITS      = 32'h7000_0000;
  localparam logic [SEC_W-1:0] SEC_EDGE_BITS  = 32'h1041_0000;

  // secondary group summaries: group g lands on primary bit GRP_PRI_BIT[g]
  localparam int NUM_GRP = 3;
  localparam logic [SEC_W-1:0] GRP_SEC_MASK [NUM_GRP] =
    '{32'hFFFF_0000, 32'h0000_FF00, 32'h0000_00FF};
  localparam int GRP_PRI_BIT [NUM_GRP] = '{4, 5, 6};
  localparam int SUM_LO = 4;
  localparam int SUM_HI = 6;

  typedef enum logic [ADDR_W-1:0] {
    RA_PSTAT = 3'd0,
    RA_PMASK = 3'd1,
    RA_PHARD = 3'd2,
    RA_PSOFT = 3'd3,
    RA_SSTAT = 3'd4,
    RA_SMASK = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int           W         = 32,
  parameter logic [W-1:0] EDGE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] latch_q, latch_d;
  logic         latch_en;

  // a zero written clears, a one keeps; a fresh edge always sets
  always_comb begin
    latch_d  = latch_q;
    if (clr_wr_i) latch_d = latch_q & clr_data_i;
    latch_d  = (latch_d | rise_i) & EDGE_MASK;
    latch_en = clr_wr_i | (|(rise_i & EDGE_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/irq_lowest_set.sv
module irq_lowest_set #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRI_W-1:0]  pri_src_i,
  input  logic [SEC_W-1:0]  sec_src_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [PRI_W-1:0]  reg_wdata_i,
  output logic [PRI_W-1:0]  reg_rdata_o,
  output logic              cpu_irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  logic [PRI_W-1:0] pri_lvl, pri_rise, pri_hard_q, pri_stat, pri_pend;
  logic [SEC_W-1:0] sec_lvl, sec_rise, sec_hard_q, sec_stat, sec_pend;
  logic [PRI_W-1:0] pri_mask_q, pri_mask_d, soft_q, soft_d;
  logic [SEC_W-1:0] sec_mask_q, sec_mask_d;
  logic             pri_mask_en, soft_en, sec_mask_en;
  logic             wr_phard, wr_sstat;
  logic [PRI_W-1:0] sum_bits;
  logic             pri_any, sec_any;
  logic [IDX_W-1:0] pri_idx;
  logic [$clog2(SEC_W)-1:0] sec_idx;
  logic             sel_sec;

  // synchronizers and edge detectors
  irq_sync_edge #(.W(PRI_W)) u_pri_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pri_src_i),
    .level_o(pri_lvl), .rise_o(pri_rise)
  );
  irq_sync_edge #(.W(SEC_W)) u_sec_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sec_src_i),
    .level_o(sec_lvl), .rise_o(sec_rise)
  );

  assign wr_phard = reg_wr_i && (reg_addr_i == RA_PHARD);
  assign wr_sstat = reg_wr_i && (reg_addr_i == RA_SSTAT);

  // sticky latches for edge sources
  irq_edge_latch #(.W(PRI_W), .EDGE_MASK(PRI_EDGE_BITS)) u_pri_latch (
    .clk(clk), .rst_n(rst_n), .rise_i(pri_rise),
    .clr_wr_i(wr_phard), .clr_data_i(reg_wdata_i), .latch_o(pri_hard_q)
  );
  irq_edge_latch #(.W(SEC_W), .EDGE_MASK(SEC_EDGE_BITS)) u_sec_latch (
    .clk(clk), .rst_n(rst_n), .rise_i(sec_rise),
    .clr_wr_i(wr_sstat), .clr_data_i(reg_wdata_i), .latch_o(sec_hard_q)
  );

  // mask and soft register next state
  always_comb begin
    pri_mask_d  = reg_wdata_i;
    sec_mask_d  = reg_wdata_i;
    soft_d      = reg_wdata_i & SOFT_BITS;
    pri_mask_en = reg_wr_i && (reg_addr_i == RA_PMASK);
    sec_mask_en = reg_wr_i && (reg_addr_i == RA_SMASK);
    soft_en     = reg_wr_i && (reg_addr_i == RA_PSOFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_mask_q <= '0;
      sec_mask_q <= '0;
      soft_q     <= '0;
    end else begin
      if (pri_mask_en) pri_mask_q <= pri_mask_d;
      if (sec_mask_en) sec_mask_q <= sec_mask_d;
      if (soft_en)     soft_q     <= soft_d;
    end
  end

  // secondary status and pending set
  assign sec_stat = (sec_lvl & ~SEC_EDGE_BITS) | sec_hard_q;
  assign sec_pend = sec_stat & sec_mask_q;

  // group summaries onto fixed primary bits
  always_comb begin
    sum_bits = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      sum_bits[GRP_PRI_BIT[g]] = |(sec_pend & GRP_SEC_MASK[g]);
    end
  end

  assign pri_stat = (pri_lvl & PRI_LEVEL_BITS) | pri_hard_q
                  | (soft_q & SOFT_BITS) | (sum_bits & PRI_SUM_BITS);
  assign pri_pend = pri_stat & pri_mask_q;

  // priority resolution
  irq_lowest_set #(.W(PRI_W)) u_pri_enc (
    .req_i(pri_pend), .any_o(pri_any), .idx_o(pri_idx)
  );
  irq_lowest_set #(.W(SEC_W)) u_sec_enc (
    .req_i(sec_pend), .any_o(sec_any), .idx_o(sec_idx)
  );

  assign sel_sec = (pri_idx >= IDX_W'(SUM_LO)) && (pri_idx <= IDX_W'(SUM_HI));

  always_comb begin
    vec_o = '0;
    if (pri_any) begin
      if (sel_sec && sec_any) vec_o = VEC_W'(SEC_VEC_BASE) + VEC_W'(sec_idx);
      else                    vec_o = VEC_W'(pri_idx);
    end
  end

  assign cpu_irq_o   = pri_any;
  assign vec_valid_o = pri_any;

  // register read port
  always_comb begin
    case (reg_addr_i)
      RA_PSTAT: reg_rdata_o = pri_stat;
      RA_PMASK: reg_rdata_o = pri_mask_q;
      RA_PHARD: reg_rdata_o = pri_hard_q;
      RA_PSOFT: reg_rdata_o = soft_q;
      RA_SSTAT: reg_rdata_o = sec_stat;
      RA_SMASK: reg_rdata_o = sec_mask_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [PRI_W-1:0]  reg_wdata_i,
  input logic              cpu_irq_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [PRI_W-1:0]  pri_mask_q,
  input logic [PRI_W-1:0]  pri_hard_q,
  input logic [SEC_W-1:0]  sec_hard_q
);
  logic [PRI_W-1:0] keep_pri;
  logic [SEC_W-1:0] keep_sec;

  always_comb begin
    keep_pri = (reg_wr_i && reg_addr_i == RA_PHARD) ? reg_wdata_i : '1;
    keep_sec = (reg_wr_i && reg_addr_i == RA_SSTAT) ? reg_wdata_i : '1;
  end

  // R4: a latched primary bit survives unless a zero is written to it
  a_r4_pri_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pri_hard_q & $past(pri_hard_q & keep_pri)) == $past(pri_hard_q & keep_pri)));

  // R7: same for the secondary edge latches
  a_r7_sec_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sec_hard_q & $past(sec_hard_q & keep_sec)) == $past(sec_hard_q & keep_sec)));

  // R9: nothing reaches the CPU with all primary mask bits clear
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_mask_q == '0) |-> (!cpu_irq_o && !vec_valid_o));

  // R10: a valid vector is never a summary position and stays below 64
  a_r10_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ((vec_o < 7'd64) && !(vec_o >= 7'd4 && vec_o <= 7'd6)));

  // R11: a secondary vector needs an enabled summary bit
  a_r11_sec_vec_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_o >= 7'd32) |-> (|pri_mask_q[6:4]));
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .cpu_irq_o(cpu_irq_o), .vec_valid_o(vec_valid_o),
  .vec_o(vec_o), .pri_mask_q(pri_mask_q), .pri_hard_q(pri_hard_q),
  .sec_hard_q(sec_hard_q)
);

// File: tb/irq_cascade_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pri_src, sec_src, wdata, rdata;
  logic        wr;
  logic [2:0]  addr;
  logic        cpu_irq, vvalid;
  logic [6:0]  vec;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .pri_src_i(pri_src), .sec_src_i(sec_src),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .cpu_irq_o(cpu_irq), .vec_o(vec), .vec_valid_o(vvalid)
  );

  typedef struct packed {
    logic [31:0] psrc;
    logic [31:0] ssrc;
    logic [31:0] pmask;
    logic [31:0] smask;
    logic        irq;
    logic [6:0]  vec;
  } vec_t;

  // level-only scenarios: R9, R10, R11, R8
  localparam int NV = 8;
  localparam vec_t TBL [0:NV-1] = '{
    '{32'h0000_0001, 32'h0,         32'hFFFF_FFFF, 32'h0,         1'b1, 7'd0},
    '{32'h0000_0088, 32'h0,         32'hFFFF_FFF7, 32'h0,         1'b1, 7'd7},
    '{32'h0000_0100, 32'h0,         32'h0,         32'h0,         1'b0, 7'd0},
    '{32'h0,         32'h0000_0200, 32'h0000_0020, 32'h0000_0200, 1'b1, 7'd41},
    '{32'h0000_0001, 32'h0000_0004, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 7'd0},
    '{32'h0200_0000, 32'h0002_0000, 32'h0200_0010, 32'h0002_0000, 1'b1, 7'd49},
    '{32'h0,         32'h0002_0004, 32'h0000_0040, 32'h0002_0000, 1'b0, 7'd0},
    '{32'h0000_2000, 32'h0,         32'h0000_2000, 32'h0,         1'b1, 7'd13}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pri_src = '0; sec_src = '0; wr = 1'b0; addr = '0; wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    reg_read(3'd1, r); check("R1 pmask", r, 32'h0);
    reg_read(3'd2, r); check("R1 phard", r, 32'h0);
    reg_read(3'd3, r); check("R1 soft", r, 32'h0);
    reg_read(3'd4, r); check("R1 sstat", r, 32'h0);
    reg_read(3'd5, r); check("R1 smask", r, 32'h0);
    check("R1 irq", {31'b0, cpu_irq}, 32'h0);
    check("R1 valid", {31'b0, vvalid}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      reg_write(3'd1, TBL[i].pmask);
      reg_write(3'd5, TBL[i].smask);
      pri_src = TBL[i].psrc;
      sec_src = TBL[i].ssrc;
      settle(4);
      check("R9 irq", {31'b0, cpu_irq}, {31'b0, TBL[i].irq});
      check("R9 valid", {31'b0, vvalid}, {31'b0, TBL[i].irq});
      if (TBL[i].irq) check("R10/R11 vec", {25'b0, vec}, {25'b0, TBL[i].vec});
    end
    pri_src = '0; sec_src = '0;
    reg_write(3'd1, 32'h0);
    reg_write(3'd5, 32'h0);
    settle(4);

    // R2 level follow
    pri_src = 32'h0000_0200; settle(4);
    reg_read(3'd0, r); check("R2 level high", r, 32'h0000_0200);
    pri_src = '0; settle(4);
    reg_read(3'd0, r); check("R2 level drop", r, 32'h0);

    // R3 edge latch
    pri_src[17] = 1'b1; settle(4); pri_src[17] = 1'b0;
    pri_src[23] = 1'b1; settle(4); pri_src[23] = 1'b0; settle(4);
    reg_read(3'd2, r); check("R3 phard", r, 32'h0082_0000);
    reg_read(3'd0, r); check("R3 pstat", r, 32'h0082_0000);

    // R4 write-zero clear
    reg_write(3'd2, ~32'h0002_0000);
    reg_read(3'd2, r); check("R4 partial clear", r, 32'h0080_0000);
    reg_write(3'd2, 32'h0);
    reg_read(3'd2, r); check("R4 full clear", r, 32'h0);

    // R5 new edge against clear on the same edge
    pri_src[19] = 1'b1; settle(4); pri_src[19] = 1'b0; settle(4);
    @(negedge clk); pri_src[19] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr = 1'b1; addr = 3'd2; wdata = ~32'h0008_0000;
    @(negedge clk); wr = 1'b0; wdata = '0;
    reg_read(3'd2, r); check("R5 edge wins", r, 32'h0008_0000);
    pri_src = '0; settle(4);
    reg_write(3'd2, 32'h0);
    reg_read(3'd2, r); check("R5 clear after", r, 32'h0);

    // R6 soft register
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_read(3'd3, r); check("R6 soft bits", r, 32'h7000_0000);
    reg_read(3'd0, r); check("R6 soft in status", r, 32'h7000_0000);
    reg_write(3'd1, 32'h6000_0000);
    @(negedge clk); #1;
    check("R6 soft irq", {31'b0, cpu_irq}, 32'h1);
    check("R6 soft vec", {25'b0, vec}, 32'd29);
    reg_write(3'd3, 32'h0);
    reg_write(3'd1, 32'h0);

    // R7 secondary edge and level
    sec_src[22] = 1'b1; settle(4); sec_src[22] = 1'b0; settle(4);
    reg_read(3'd4, r); check("R7 sec edge latched", r, 32'h0040_0000);
    reg_write(3'd4, ~32'h0040_0000);
    reg_read(3'd4, r); check("R7 sec edge cleared", r, 32'h0);
    sec_src = 32'h0000_0008; settle(4);
    reg_read(3'd4, r); check("R7 sec level", r, 32'h0000_0008);

    // R8 summary in primary status
    reg_write(3'd5, 32'h0000_0008);
    reg_read(3'd0, r); check("R8 audio summary", r, 32'h0000_0040);
    reg_write(3'd5, 32'h0);
    reg_read(3'd0, r); check("R8 summary masked", r, 32'h0);
    sec_src = '0; settle(4);

    // R12 read-only and unused addresses
    reg_read(3'd7, r); check("R12 unused addr", r, 32'h0);
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd1, r); check("R12 pmask untouched", r, 32'h0);
    reg_read(3'd2, r); check("R12 phard untouched", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule